// File: doc/BRIEF.md
# GPIO Pin Interrupt Detection Unit

This block turns a bank of general-purpose input pins into interrupt requests. For each pin, two configuration bits choose what counts as an interrupt. A type bit selects edge sensing or level sensing. A polarity bit selects rising edges or high levels against falling edges or low levels. A per-pin enable turns detection on. A per-pin mask hides a pin from the reported status without discarding a latched edge. The configuration values arrive as plain vectors from a register bank elsewhere on the chip. This block does no bus decoding.

Edge events are held by a small two-state machine in each pin, with the states DET_IDLE and DET_PENDING. An event in edge mode moves the pin from DET_IDLE to DET_PENDING. An end-of-interrupt write pulse carries a vector, and each 1 in it returns the matching pin to DET_IDLE. Leaving edge mode, or clearing the enable, also forces the pin back to DET_IDLE.

Each pin can optionally pass through a debounce filter before detection. The filter is a two-state machine with the states DB_HOLD and DB_WAIT. It sits in DB_HOLD while its output agrees with the raw pin. It moves to DB_WAIT when they differ. From DB_WAIT it returns to DB_HOLD in two cases: the raw pin reverts, which rejects the glitch, or the raw pin has stayed changed for DEB_TICKS strobes of a slow sample enable, in which case the filter accepts the new value. Both-edge detection is not built in. Software gets it by flipping the polarity after each event, so a polarity change alone must never look like an event.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is asserted and right after it is released, irq_vec is all zeros and irq_any is 0.
- R2: With cfg_edge[i]=1 and cfg_en[i]=1, a 0-to-1 transition of the pin with cfg_pol[i]=1, or a 1-to-0 transition with cfg_pol[i]=0, sets irq_vec[i] at the next rising clock edge. The bit stays set after the pin returns to its earlier level. The opposite transition creates no event.
- R3: With cfg_edge[i]=0 and cfg_en[i]=1, irq_vec[i] follows the pin one clock later. It is 1 while the pin is high (cfg_pol[i]=1) or low (cfg_pol[i]=0), and 0 otherwise.
- R4: A pin with cfg_en[i]=0 latches no events and shows 0 in irq_vec[i] from the next clock on, whatever its input does.
- R5: cfg_mask[i]=1 forces irq_vec[i] to 0 and removes pin i from irq_any one clock later. A latched edge is kept, and it reappears one clock after the mask bit returns to 0.
- R6: A cycle with eoi_wr=1 returns every edge-mode pin whose eoi_data bit is 1 to idle, visible one clock later. Pins whose eoi_data bit is 0 keep their pending edge. Level-mode pins are not affected.
- R7: When a new edge event and an end-of-interrupt clear for the same pin fall in the same cycle, the pin stays pending.
- R8: Changing cfg_pol[i] on an edge-mode pin whose input is stable creates no event.
- R9: With cfg_deb[i]=1, detection sees a filtered pin. The filter takes a new value only after the raw pin has differed from it for DEB_TICKS cycles with sample_tick=1, and the filter output changes only in cycles with sample_tick=1. A change that reverts earlier is discarded. The status follows one clock after the filter changes.
- R10: irq_any is a register that equals the OR of irq_vec in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | NPINS | Raw pin levels, synchronous to clk |
| sample_tick | input | 1 | Slow strobe that paces the debounce filters |
| cfg_en | input | NPINS | Per-pin detection enable |
| cfg_mask | input | NPINS | Per-pin mask, 1 hides the pin from the outputs |
| cfg_edge | input | NPINS | Per-pin type, 1 for edge sensing and 0 for level sensing |
| cfg_pol | input | NPINS | Per-pin polarity, 1 for rising or high and 0 for falling or low |
| cfg_deb | input | NPINS | Per-pin debounce select |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_data | input | NPINS | End-of-interrupt vector, each 1 clears that pin's latched edge |
| irq_vec | output | NPINS | Registered per-pin interrupt status after masking |
| irq_any | output | 1 | Registered combined interrupt request |

## Verification
Most results are due one rising clock edge after their stimulus. This holds for a raw pin change in either sensing mode, a configuration change, a mask change and an end-of-interrupt pulse. On the debounced path, the filter moves at the edge that carries the DEB_TICKS-th strobe, and the status follows at the next edge. The bench drives every input at the falling clock edge. It then waits exactly the number of rising edges each path needs and samples at the following falling edge. It also samples one step early wherever a result must not yet have appeared, for example after too few strobes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [0:0] {
        DB_HOLD = 1'b0,
        DB_WAIT = 1'b1
    } db_state_t;

    typedef enum logic [0:0] {
        DET_IDLE    = 1'b0,
        DET_PENDING = 1'b1
    } det_state_t;

    function automatic logic lvl_active(input logic v, input logic pol);
        return pol ? v : ~v;
    endfunction

endpackage

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
    parameter int DEB_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic dout
);
    import gpio_irq_pkg::*;

    localparam int CNT_W = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_TICKS - 1);

    db_state_t        st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             out_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= DB_HOLD;
            cnt  <= '0;
            dout <= 1'b0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            dout <= out_n;
        end
    end

    // next state and output value
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        out_n = dout;
        unique case (st)
            DB_HOLD: begin
                if (din != dout) begin
                    st_n  = DB_WAIT;
                    cnt_n = '0;
                end
            end
            DB_WAIT: begin
                if (din == dout) begin
                    st_n = DB_HOLD;
                end else if (tick) begin
                    if (cnt == LAST) begin
                        out_n = din;
                        st_n  = DB_HOLD;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            default: st_n = DB_HOLD;
        endcase
    end

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic en,
    input  logic edge_sel,
    input  logic pol,
    input  logic mask,
    input  logic clr,
    output logic stat_d,
    output logic stat_q
);
    import gpio_irq_pkg::*;

    det_state_t st, st_n;
    logic       sig_q;
    logic       rise, fall, evt, raw;

    // an event needs a real transition of the input, so a polarity flip alone never fires
    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
    assign evt  = pol ? rise : fall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= DET_IDLE;
            sig_q <= 1'b0;
        end else begin
            st    <= st_n;
            sig_q <= sig;
        end
    end

    // next state
    always_comb begin
        st_n = st;
        if (!(en && edge_sel)) begin
            st_n = DET_IDLE;
        end else begin
            unique case (st)
                DET_IDLE:    if (evt)         st_n = DET_PENDING;
                DET_PENDING: if (clr && !evt) st_n = DET_IDLE;
                default:                      st_n = DET_IDLE;
            endcase
        end
    end

    // outputs
    assign raw    = en & (edge_sel ? (st_n == DET_PENDING) : lvl_active(sig, pol));
    assign stat_d = raw & ~mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= 1'b0;
        else        stat_q <= stat_d;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int NPINS     = 32,
    parameter int DEB_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic             sample_tick,
    input  logic [NPINS-1:0] cfg_en,
    input  logic [NPINS-1:0] cfg_mask,
    input  logic [NPINS-1:0] cfg_edge,
    input  logic [NPINS-1:0] cfg_pol,
    input  logic [NPINS-1:0] cfg_deb,
    input  logic             eoi_wr,
    input  logic [NPINS-1:0] eoi_data,
    output logic [NPINS-1:0] irq_vec,
    output logic             irq_any
);

    logic [NPINS-1:0] deb_val;
    logic [NPINS-1:0] filt;
    logic [NPINS-1:0] clr;
    logic [NPINS-1:0] stat_d;

    assign clr = eoi_wr ? eoi_data : '0;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_debounce #(
            .DEB_TICKS (DEB_TICKS)
        ) u_deb (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (sample_tick),
            .din   (pin_in[i]),
            .dout  (deb_val[i])
        );

        assign filt[i] = cfg_deb[i] ? deb_val[i] : pin_in[i];

        gpio_pin_detect u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .sig      (filt[i]),
            .en       (cfg_en[i]),
            .edge_sel (cfg_edge[i]),
            .pol      (cfg_pol[i]),
            .mask     (cfg_mask[i]),
            .clr      (clr[i]),
            .stat_d   (stat_d[i]),
            .stat_q   (irq_vec[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_any <= 1'b0;
        else        irq_any <= |stat_d;
    end

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_tick,
    input logic [NPINS-1:0] cfg_en,
    input logic [NPINS-1:0] cfg_mask,
    input logic [NPINS-1:0] irq_vec,
    input logic             irq_any,
    input logic [NPINS-1:0] deb_val
);

    a_r10_any_is_or: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (|irq_vec));

    a_r5_mask_hides: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_vec & $past(cfg_mask)) == '0));

    a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_vec & ~$past(cfg_en)) == '0));

    a_r9_filter_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> $stable(deb_val));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .cfg_en      (cfg_en),
    .cfg_mask    (cfg_mask),
    .irq_vec     (irq_vec),
    .irq_any     (irq_any),
    .deb_val     (deb_val)
);

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb;

    localparam int N  = 8;
    localparam int DT = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic         sample_tick = 1'b0;
    logic [N-1:0] cfg_en = '0, cfg_mask = '0, cfg_edge = '0, cfg_pol = '0, cfg_deb = '0;
    logic         eoi_wr = 1'b0;
    logic [N-1:0] eoi_data = '0;
    logic [N-1:0] irq_vec;
    logic         irq_any;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    gpio_irq_detect #(.NPINS(N), .DEB_TICKS(DT)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sample_tick(sample_tick),
        .cfg_en(cfg_en), .cfg_mask(cfg_mask), .cfg_edge(cfg_edge), .cfg_pol(cfg_pol),
        .cfg_deb(cfg_deb), .eoi_wr(eoi_wr), .eoi_data(eoi_data),
        .irq_vec(irq_vec), .irq_any(irq_any)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic eoi(input logic [N-1:0] v);
        eoi_wr = 1'b1; eoi_data = v;
        step(1);
        eoi_wr = 1'b0; eoi_data = '0;
    endtask

    task automatic ticks(input int n);
        sample_tick = 1'b1;
        step(n);
        sample_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [N-1:0] inact, act, bit_p;
        @(negedge clk);
        step(2);
        chk("R1 reset vec", irq_vec, 0);
        chk("R1 reset any", irq_any, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 after release", irq_vec, 0);

        // sweep every pin through all four sensing modes; other pins toggle while disabled (R4)
        for (int p = 0; p < N; p++) begin
            for (int m = 0; m < 4; m++) begin
                bit_p = N'(1) << p;
                inact = m[0] ? '0 : '1;
                act   = ~inact;
                cfg_en = '0; cfg_mask = '0; cfg_deb = '0;
                pin_in = inact;
                step(2);
                cfg_edge = m[1] ? '1 : '0;
                cfg_pol  = m[0] ? '1 : '0;
                cfg_en   = bit_p;
                step(1);
                chk("R4 idle", irq_vec, 0);
                pin_in = act;
                step(1);
                chk(m[1] ? "R2 edge event" : "R3 level active", irq_vec, bit_p);
                chk("R10 any set", irq_any, 1);
                pin_in = inact;
                step(1);
                chk(m[1] ? "R2 edge latched" : "R3 level inactive", irq_vec, m[1] ? bit_p : '0);
                eoi('1);
                chk("R6 eoi all", irq_vec, 0);
                chk("R10 any clear", irq_any, 0);
                pin_in = act;
                step(1);
                if (!m[1]) begin
                    eoi('1);
                    chk("R6 level ignores eoi", irq_vec, bit_p);
                end
                cfg_mask = bit_p;
                step(1);
                chk("R5 masked vec", irq_vec, 0);
                chk("R5 masked any", irq_any, 0);
                cfg_mask = '0;
                step(1);
                chk("R5 unmask restores", irq_vec, bit_p);
                cfg_en = '0;
                step(1);
                chk("R4 disable clears", irq_vec, 0);
            end
        end

        // R6 selective clear
        cfg_en = '0; pin_in = '0; cfg_edge = '1; cfg_pol = '1;
        step(2);
        cfg_en = 8'h06;
        step(1);
        pin_in = 8'h06;
        step(1);
        chk("R6 two pending", irq_vec, 8'h06);
        eoi(8'h02);
        chk("R6 selective clear", irq_vec, 8'h04);

        // R7 same-cycle event and clear
        cfg_en = '0; pin_in = '0;
        step(2);
        cfg_en = 8'h08;
        step(1);
        pin_in = 8'h08;
        step(1);
        chk("R7 first pending", irq_vec, 8'h08);
        pin_in = '0;
        step(1);
        pin_in = 8'h08;
        eoi(8'h08);
        chk("R7 edge wins", irq_vec, 8'h08);
        step(1);
        chk("R7 still pending", irq_vec, 8'h08);

        // R8 polarity flip on a stable high input
        cfg_en = '0; pin_in = '0;
        step(2);
        cfg_en = 8'h20;
        step(1);
        pin_in = 8'h20;
        step(1);
        eoi('1);
        chk("R8 cleared", irq_vec, 0);
        cfg_pol = '0;
        step(2);
        chk("R8 no false event", irq_vec, 0);
        pin_in = '0;
        step(1);
        chk("R8 falling after flip", irq_vec, 8'h20);

        // R9 debounce on pin 0, rising edge
        cfg_en = '0; pin_in = '0; cfg_pol = '1;
        step(2);
        cfg_deb = 8'h01; cfg_en = 8'h01;
        step(1);
        pin_in = 8'h01;
        step(10);
        chk("R9 no ticks no change", irq_vec, 0);
        ticks(DT - 1);
        step(3);
        chk("R9 too few ticks", irq_vec, 0);
        ticks(1);
        chk("R9 filter moved, status not yet", irq_vec, 0);
        step(1);
        chk("R9 accepted after DEB_TICKS", irq_vec, 8'h01);
        eoi('1);
        pin_in = '0;
        step(1);
        ticks(DT);
        step(1);
        chk("R9 falling ignored for rising pol", irq_vec, 0);
        pin_in = 8'h01;
        step(1);
        ticks(DT - 2);
        pin_in = '0;
        step(1);
        ticks(DT + 2);
        step(2);
        chk("R9 glitch rejected", irq_vec, 0);
        chk("R10 any idle", irq_any, 0);

        finish_run();
    end

endmodule